// File: doc/BRIEF.md
# Pulse-Position Command Decoder

This block recovers command bytes sent from a reader to a tag when the reader uses pulse-position coding. The sender marks each symbol by pulling the carrier envelope low ("a drop") in exactly one slot of a frame. Each slot is split into two halves. The decoder takes one envelope sample per half-slot, qualified by a valid strobe, with 1 for carrier present and 0 for a drop.

While the decoder is idle, it waits for a long quiet stretch followed by a drop, and treats that drop as the start of a frame. The slot that carries the next drop decides between two codings. In the short coding, each 4-slot frame carries two bits. In the long coding, each 256-slot frame carries a full byte. Decoded bytes go into a small buffer that can be read at any time. A first-half drop in the leading slot of a frame closes the command and produces a one-clock completion pulse together with the byte count. Any coding violation drops the decoder back to idle without a completion pulse.

Top module: `ppm_cmd_decoder`

## Requirements
- R1: After reset, `busy`, `frame_done`, `overflow` and `mode_256` are 0 and `frame_len` is 0.
- R2: While idle, a valid low sample starts a frame (`busy` becomes 1) only if it directly follows at least 8 consecutive valid high samples. A low sample after a shorter run does not start a frame and restarts the count.
- R3: The low sample that starts a frame is the first half of slot 1 of a 4-slot start frame. A second-half drop in slot 3 selects the short coding (`mode_256`=0). A second-half drop in slot 4 selects the long coding (`mode_256`=1). A drop in any other slot returns the block to idle.
- R4: In the short coding, each 4-slot frame yields the value (drop slot − 1) in 0..3. This value enters bits [7:6] of a register that shifts right by two. After four frames the register is stored as a byte, so the first frame supplies bits [1:0].
- R5: In the long coding, each 256-slot frame stores one byte equal to (drop slot − 1). Slot 1 gives 0x00 and slot 256 gives 0xFF.
- R6: A second drop inside one symbol frame returns the block to idle with no completion pulse.
- R7: A symbol frame that ends without any drop returns the block to idle with no completion pulse.
- R8: While receiving, a first-half drop in slot 1 of a new frame ends the command and the block goes idle. If at least one byte was stored, `frame_done` is high for exactly one clock with `frame_len` equal to the byte count. Otherwise no pulse is raised.
- R9: While receiving, a first-half drop in any slot other than slot 1 returns the block to idle with no completion pulse.
- R10: The buffer holds 32 bytes. Bytes decoded beyond that are discarded, `overflow` rises, and the command still completes with `frame_len` = 32 and the stored bytes intact.
- R11: Buffer contents (read at `rd_addr`), `frame_len` and `overflow` hold their values until the next start of frame, which clears `frame_len` and `overflow` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One half-slot sample is present this cycle |
| smp_level | input | 1 | Envelope level of the sample, 0 = drop |
| rd_addr | input | 5 | Buffer read index |
| rd_data | output | 8 | Byte stored at `rd_addr` (combinational read) |
| busy | output | 1 | A frame is being decoded |
| mode_256 | output | 1 | Long coding selected by the current start frame |
| frame_done | output | 1 | One-clock completion pulse |
| frame_len | output | 6 | Number of bytes stored in the current or last command |
| overflow | output | 1 | Bytes were discarded because the buffer was full |

## Verification
The bench builds the decoder with its default parameters: a 32-byte buffer, an 8-sample quiet run, and 256-slot long frames. With these values the overflow path can be reached after only 33 short-coded bytes. Long frames are exercised at both of their extreme slots (first and last). A behavioural model follows every sample and is compared with the status outputs on every clock. Directed sequences cover each kind of coding violation, as well as the near-miss quiet run of 7 samples.

// File: rtl/ppm_pkg.sv
`timescale 1ns/1ps
package ppm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SOF  = 2'd1,
    PH_RX   = 2'd2
  } ph_t;

  localparam int START_SLOTS = 4;

  // Short coding: push (slot-1) into the top pair, older pairs move down.
  function automatic logic [7:0] pair_push(input logic [7:0] acc,
                                           input logic [1:0] slot_lo);
    logic [1:0] code;
    code = slot_lo - 2'd1;
    return {code, acc[7:2]};
  endfunction

endpackage

// File: rtl/ppm_idle_hunt.sv
`timescale 1ns/1ps
module ppm_idle_hunt #(
  parameter int RUN_MIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic smp_valid,
  input  logic smp_level,
  output logic start_hit
);
  localparam int RW = $clog2(RUN_MIN + 1);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_MIN);

  logic [RW-1:0] run_q;

  assign start_hit = armed && smp_valid && !smp_level && (run_q == RUN_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || !armed) begin
      run_q <= '0;
    end else if (smp_valid) begin
      if (smp_level) begin
        if (run_q != RUN_TOP) run_q <= run_q + RW'(1);
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ppm_byte_store.sv
`timescale 1ns/1ps
module ppm_byte_store #(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [7:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       room;

  assign room    = (count < CAP);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (wr_en) begin
      if (room) count <= count + CW'(1);
      else      overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clear && room) mem[count[AW-1:0]] <= wr_data;
  end
endmodule

// File: rtl/ppm_cmd_decoder.sv
`timescale 1ns/1ps
module ppm_cmd_decoder #(
  parameter int DEPTH      = 32,
  parameter int RUN_MIN    = 8,
  parameter int LONG_SLOTS = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic                       smp_level,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [7:0]                 rd_data,
  output logic                       busy,
  output logic                       mode_256,
  output logic                       frame_done,
  output logic [$clog2(DEPTH+1)-1:0] frame_len,
  output logic                       overflow
);
  import ppm_pkg::*;

  localparam int SW = $clog2(LONG_SLOTS + 1);
  localparam logic [SW-1:0] TOP_SHORT = SW'(START_SLOTS);
  localparam logic [SW-1:0] TOP_LONG  = SW'(LONG_SLOTS);

  function automatic logic [7:0] slot_byte(input logic [SW-1:0] s);
    logic [SW-1:0] t;
    t = s - SW'(1);
    return t[7:0];
  endfunction

  ph_t         ph;
  logic        half_b;      // 1: next sample is the second half of a slot
  logic [SW-1:0] slot_cnt;  // slots completed in the current frame
  logic [SW-1:0] drop_pos;  // slot index of the drop, 0 = none yet
  logic        mode_long;
  logic [7:0]  acc;
  logic [1:0]  pairs;
  logic        done_q;

  // Named internal events
  logic          start_hit, active, first_low, second;
  logic          eof_hit, early_err, dbl_err, empty_err, sof_bad, err_hit;
  logic          frame_end, sof_long, sof_short, sym_ok, byte_wr;
  logic [SW-1:0] slot_nx, drop_nx, frame_top;
  logic [7:0]    acc_nx, byte_val;

  assign active    = smp_valid && (ph != PH_IDLE);
  assign first_low = active && !half_b && !smp_level;
  assign eof_hit   = first_low && (ph == PH_RX) && (slot_cnt == '0);
  assign early_err = first_low && (ph == PH_RX) && (slot_cnt != '0);
  assign second    = active && half_b;
  assign slot_nx   = slot_cnt + SW'(1);
  assign dbl_err   = second && !smp_level && (drop_pos != '0);
  assign drop_nx   = (second && !smp_level && (drop_pos == '0)) ? slot_nx : drop_pos;
  assign frame_top = ((ph == PH_SOF) || !mode_long) ? TOP_SHORT : TOP_LONG;
  assign frame_end = second && !dbl_err && (slot_nx == frame_top);
  assign sof_long  = frame_end && (ph == PH_SOF) && (drop_nx == SW'(4));
  assign sof_short = frame_end && (ph == PH_SOF) && (drop_nx == SW'(3));
  assign sof_bad   = frame_end && (ph == PH_SOF) && !sof_long && !sof_short;
  assign empty_err = frame_end && (ph == PH_RX) && (drop_nx == '0);
  assign sym_ok    = frame_end && (ph == PH_RX) && (drop_nx != '0);
  assign err_hit   = early_err || dbl_err || empty_err || sof_bad;
  assign acc_nx    = pair_push(acc, drop_nx[1:0]);
  assign byte_wr   = sym_ok && (mode_long || (pairs == 2'd3));
  assign byte_val  = mode_long ? slot_byte(drop_nx) : acc_nx;

  ppm_idle_hunt #(.RUN_MIN(RUN_MIN)) hunt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (ph == PH_IDLE),
    .smp_valid (smp_valid),
    .smp_level (smp_level),
    .start_hit (start_hit)
  );

  ppm_byte_store #(.DEPTH(DEPTH)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_hit),
    .wr_en    (byte_wr),
    .wr_data  (byte_val),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .count    (frame_len),
    .overflow (overflow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      half_b    <= 1'b0;
      slot_cnt  <= '0;
      drop_pos  <= '0;
      mode_long <= 1'b0;
      acc       <= '0;
      pairs     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= eof_hit && (frame_len != '0);
      if (start_hit) begin
        ph        <= PH_SOF;
        half_b    <= 1'b1;
        slot_cnt  <= '0;
        drop_pos  <= '0;
        mode_long <= 1'b0;
        acc       <= '0;
        pairs     <= '0;
      end else if (err_hit || eof_hit) begin
        ph <= PH_IDLE;
      end else if (active) begin
        half_b <= !half_b;
        if (half_b) begin
          if (frame_end) begin
            slot_cnt <= '0;
            drop_pos <= '0;
            if (sof_long || sof_short) begin
              ph        <= PH_RX;
              mode_long <= sof_long;
            end
            if (sym_ok && !mode_long) begin
              acc   <= acc_nx;
              pairs <= pairs + 2'd1;
            end
          end else begin
            slot_cnt <= slot_nx;
            drop_pos <= drop_nx;
          end
        end
      end
    end
  end

  assign busy       = (ph != PH_IDLE);
  assign mode_256   = mode_long;
  assign frame_done = done_q;
endmodule

// File: rtl/ppm_cmd_decoder_chk.sv
`timescale 1ns/1ps
module ppm_cmd_decoder_chk #(
  parameter int DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       frame_done,
  input logic [$clog2(DEPTH+1)-1:0] frame_len,
  input logic                       overflow,
  input logic                       start_hit,
  input logic                       eof_hit,
  input logic                       err_hit
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |-> !busy);
  assert_start_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> busy);
  assert_err_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> (!busy && !frame_done));
  assert_eof_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_hit |=> !busy);
  assert_done_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_done_has_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ((frame_len != '0) && !busy));
  assert_len_capped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_len <= CAP);
  assert_ovf_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (frame_len == CAP));
  assert_len_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_hit) |=> ($stable(frame_len) && $stable(overflow)));
  assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> ((frame_len == '0) && !overflow));
endmodule

bind ppm_cmd_decoder ppm_cmd_decoder_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .frame_done (frame_done),
  .frame_len  (frame_len),
  .overflow   (overflow),
  .start_hit  (start_hit),
  .eof_hit    (eof_hit),
  .err_hit    (err_hit)
);

// File: tb/ppm_cmd_decoder_tb.sv
`timescale 1ns/1ps
module ppm_cmd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_level = 1'b1;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, mode_256, frame_done, overflow;
  logic [5:0] frame_len;

  int total = 0;
  int bad = 0;
  bit chk_on = 1'b0;
  bit finished = 1'b0;
  int done_seen = 0;
  int last_len = 0;

  // Behavioural reference state
  int m_ph = 0;        // 0 idle, 1 start frame, 2 receiving
  int m_run = 0, m_half = 0, m_slot = 0, m_drop = 0;
  int m_long = 0, m_acc = 0, m_pairs = 0, m_len = 0, m_ovf = 0, m_done = 0;
  int m_mem [32];

  always #10 clk = ~clk;

  ppm_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_level(smp_level),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .mode_256(mode_256),
    .frame_done(frame_done), .frame_len(frame_len), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void m_idle();
    m_ph = 0;
    m_run = 0;
  endfunction

  function automatic void m_store(input int b);
    if (m_len < 32) begin
      m_mem[m_len] = b;
      m_len++;
    end else m_ovf = 1;
  endfunction

  function automatic void m_step(input bit v, input bit l);
    int limit, d;
    m_done = 0;
    if (!v) return;
    if (m_ph == 0) begin
      if (l) begin
        if (m_run < 8) m_run++;
      end else begin
        if (m_run >= 8) begin
          m_ph = 1; m_half = 1; m_slot = 0; m_drop = 0; m_long = 0;
          m_acc = 0; m_pairs = 0; m_len = 0; m_ovf = 0;
        end
        m_run = 0;
      end
      return;
    end
    if (m_half == 0) begin
      m_half = 1;
      if (!l && m_ph == 2) begin
        if (m_slot == 0 && m_len > 0) m_done = 1;
        m_idle();
      end
      return;
    end
    m_half = 0;
    m_slot++;
    if (!l) begin
      if (m_drop != 0) begin
        m_idle();
        return;
      end
      m_drop = m_slot;
    end
    limit = (m_ph == 1 || m_long == 0) ? 4 : 256;
    if (m_slot == limit) begin
      d = m_drop;
      m_slot = 0;
      m_drop = 0;
      if (m_ph == 1) begin
        if (d == 4) begin m_ph = 2; m_long = 1; end
        else if (d == 3) begin m_ph = 2; m_long = 0; end
        else m_idle();
      end else if (d == 0) begin
        m_idle();
      end else if (m_long != 0) begin
        m_store(d - 1);
      end else begin
        m_acc = m_acc / 4 + (d - 1) * 64;
        m_pairs++;
        if (m_pairs == 4) begin
          m_store(m_acc);
          m_pairs = 0;
        end
      end
    end
  endfunction

  // Per-clock comparison against the model, mid-cycle after each edge
  always @(posedge clk) begin
    #5;
    if (chk_on) begin
      if (frame_done) begin
        done_seen++;
        last_len = int'(frame_len);
      end
      chk(busy == (m_ph != 0), "R2 busy", int'(busy), int'(m_ph != 0));
      chk(frame_done == m_done[0], "R8 frame_done", int'(frame_done), m_done);
      chk(int'(frame_len) == m_len, "R11 frame_len", int'(frame_len), m_len);
      chk(overflow == m_ovf[0], "R10 overflow", int'(overflow), m_ovf);
      if (m_ph == 2) chk(mode_256 == m_long[0], "R3 mode_256", int'(mode_256), m_long);
    end
  end

  task automatic tick(input bit v, input bit l);
    @(negedge clk);
    smp_valid = v;
    smp_level = l;
    m_step(v, l);
  endtask

  task automatic half(input bit l);
    tick(1'b1, l);
    tick(1'b0, 1'b1);
  endtask

  task automatic highs(input int n);
    for (int i = 0; i < n; i++) half(1'b1);
  endtask

  // Quiet run, start drop, then the remainder of the 4-slot start frame
  task automatic sof(input int slot);
    highs(8);
    half(1'b0);
    half(1'b1);
    for (int s = 2; s <= 4; s++) begin
      half(1'b1);
      half(s == slot ? 1'b0 : 1'b1);
    end
  endtask

  task automatic sym(input int n, input int slot);
    for (int s = 1; s <= n; s++) begin
      half(1'b1);
      half(s == slot ? 1'b0 : 1'b1);
    end
  endtask

  task automatic byte4(input int b);
    for (int k = 0; k < 4; k++) sym(4, ((b >> (2 * k)) & 3) + 1);
  endtask

  task automatic eof();
    half(1'b0);
    half(1'b1);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 5'(a);
    #1;
    v = int'(rd_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, d0, exp31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !frame_done && !overflow && !mode_256 && frame_len == 0,
        "R1 reset", int'(busy), 0);

    // R2 near miss: only 7 highs before the drop
    highs(7);
    half(1'b0);
    chk(!busy, "R2 short run", int'(busy), 0);
    // R3 short coding, R4 bytes
    sof(3);
    chk(busy && !mode_256, "R3 short coding", int'(mode_256), 0);
    d0 = done_seen;
    byte4(8'hA5);
    byte4(8'h3C);
    eof();
    chk(done_seen == d0 + 1, "R8 done count", done_seen - d0, 1);
    chk(last_len == 2, "R8 done len", last_len, 2);
    rd(0, v); chk(v == 8'hA5, "R4 byte0", v, 8'hA5);
    rd(1, v); chk(v == 8'h3C, "R4 byte1", v, 8'h3C);

    // R11 contents held while idle
    highs(5);
    rd(1, v); chk(v == 8'h3C, "R11 held byte", v, 8'h3C);
    chk(frame_len == 2, "R11 held len", int'(frame_len), 2);

    // R5 long coding at both slot extremes
    sof(4);
    chk(busy && mode_256, "R3 long coding", int'(mode_256), 1);
    chk(frame_len == 0, "R11 cleared at start", int'(frame_len), 0);
    d0 = done_seen;
    sym(256, 1);
    sym(256, 256);
    eof();
    chk(done_seen == d0 + 1 && last_len == 2, "R5 done", last_len, 2);
    rd(0, v); chk(v == 8'h00, "R5 byte slot1", v, 0);
    rd(1, v); chk(v == 8'hFF, "R5 byte slot256", v, 255);

    // R3 bad start slot
    sof(2);
    chk(!busy, "R3 bad start", int'(busy), 0);

    // R6 two drops in one symbol
    d0 = done_seen;
    sof(3);
    half(1'b1); half(1'b0); half(1'b1); half(1'b0);
    chk(!busy && done_seen == d0, "R6 double drop", int'(busy), 0);

    // R7 symbol without drop
    sof(3);
    sym(4, 0);
    chk(!busy && done_seen == d0, "R7 empty symbol", int'(busy), 0);

    // R8 end right after start: no pulse
    sof(3);
    eof();
    chk(!busy && done_seen == d0, "R8 empty command", done_seen - d0, 0);

    // R9 first-half drop in slot 2
    sof(3);
    half(1'b1); half(1'b0); half(1'b0);
    chk(!busy && done_seen == d0, "R9 misplaced drop", int'(busy), 0);

    // R10 overflow with 33 bytes
    sof(3);
    for (int k = 0; k < 33; k++) byte4((k * 7 + 1) & 255);
    chk(overflow, "R10 overflow flag", int'(overflow), 1);
    eof();
    chk(done_seen == d0 + 1 && last_len == 32, "R10 done len", last_len, 32);
    exp31 = (31 * 7 + 1) & 255;
    rd(31, v); chk(v == exp31, "R10 last stored", v, exp31);
    rd(0, v); chk(v == 1, "R10 first stored", v, 1);

    // R11 next start clears length and overflow
    sof(3);
    chk(frame_len == 0 && !overflow, "R11 start clears", int'(overflow), 0);
    highs(2);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule